// File: doc/BRIEF.md
# GPIO Grouped Interrupt Summary

This block condenses the per-pin interrupt and wake status flags of a GPIO controller into a compact summary. Pins are taken four at a time. Each group drives one summary bit, which is set when any pin in the group has either flag raised. There are 46 groups, so 184 pins are covered. The summary is a 64-bit value presented as a low word and a high word, each 32 bits wide. Bit n of the combined value stands for pins 4n through 4n+3. The bits above group 45 are always zero.

A single upstream interrupt request is derived from the summary and gated by an enable bit in a master control register. Once the request has been raised, it stays raised and is not re-triggered until software writes the end-of-interrupt (EOI) bit of that register. If any summary bit is still set when EOI is written, a fresh request follows. This lets a handler scan the summary words, service the flagged groups, and then acknowledge with a single write.

The register write port is a plain strobe with an address and data. Only the master register is decoded here. The per-pin control registers sit at byte offset pin×4 and are handled elsewhere, so the master register is placed above that range.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n equals the OR of the interrupt and wake status of pins 4n..4n+3, registered, so it follows the inputs one clock later.
- R2: `sum_lo` carries summary bits 31..0 and `sum_hi` carries bits 63..32 (group 32 is `sum_hi[0]`, group 45 is `sum_hi[13]`).
- R3: Summary bits 46..63 (`sum_hi[31:14]`) always read as zero.
- R4: With the enable bit set and the request idle, `irq_out` rises two clocks after a status input makes the summary nonzero, which is one clock after the summary changes.
- R5: Once `irq_out` is high, it stays high until a write to the master register, even if the summary returns to zero.
- R6: A write to the master register with bit 1 (EOI) set drops `irq_out` on the following clock. If the summary is still nonzero and the enable bit is set, `irq_out` rises again one clock later. If the summary is zero, it stays low.
- R7: In the master register, bit 0 is the enable bit and is stored and read back on `master_rd[0]`. Bit 1 (EOI) is self-clearing and always reads as 0. All other bits read as 0.
- R8: While the enable bit is 0, `irq_out` is low, even when summary bits are set.
- R9: A write whose address is not `MASTER_ADDR` (default byte address 0x2FC) changes neither the master register nor `irq_out`.
- R10: After reset, both summary words, `irq_out` and `master_rd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_sts | input | 184 | Per-pin interrupt status, one bit per pin |
| wake_sts | input | 184 | Per-pin wake status, one bit per pin |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| sum_lo | output | 32 | Summary bits 31..0 |
| sum_hi | output | 32 | Summary bits 63..32 |
| irq_out | output | 1 | Upstream interrupt request (level) |
| master_rd | output | 32 | Read-back value of the master register |

## Verification
The assertions assume that the status vectors and the write strobe are synchronous to `clk` and stable around each rising edge. The bench meets this by driving every input on the falling edge. The hold property assumes that only writes to the master register may release the request. The stimulus therefore checks the effect of writes to other addresses separately, and uses the master address only for the enable and EOI writes. The bench samples the summary one clock and the request two clocks after a status change, which matches the latencies the properties encode.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int GIS_NUM_GROUPS     = 46;
  localparam int GIS_PINS_PER_GROUP = 4;
  localparam int GIS_WORD_W         = 32;
  localparam int GIS_ADDR_W         = 12;
  localparam logic [GIS_ADDR_W-1:0] GIS_MASTER_ADDR = 12'h2FC;
  localparam int GIS_EN_BIT  = 0;
  localparam int GIS_EOI_BIT = 1;
endpackage

// File: rtl/gis_group_or.sv
module gis_group_or #(
  parameter int NUM_GROUPS     = 46,
  parameter int PINS_PER_GROUP = 4,
  parameter int SUM_W          = 64,
  localparam int NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] int_sts,
  input  logic [NUM_PINS-1:0] wake_sts,
  output logic [SUM_W-1:0]    summary
);
  logic [NUM_PINS-1:0] any_flag;
  logic [SUM_W-1:0]    grp_d;

  assign any_flag = int_sts | wake_sts;

  for (genvar g = 0; g < SUM_W; g++) begin : g_bit
    if (g < NUM_GROUPS) begin : g_used
      assign grp_d[g] = |any_flag[g*PINS_PER_GROUP +: PINS_PER_GROUP];
    end else begin : g_unused
      assign grp_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary <= '0;
    else        summary <= grp_d;
  end
endmodule

// File: rtl/gis_master_reg.sv
module gis_master_reg #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = '0,
  parameter int EN_BIT  = 0,
  parameter int EOI_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              enable,
  output logic              eoi_pulse,
  output logic [WORD_W-1:0] rd_value
);
  logic hit;

  assign hit       = wr_en && (wr_addr == MASTER_ADDR);
  assign eoi_pulse = hit && wr_data[EOI_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   enable <= 1'b0;
    else if (hit) enable <= wr_data[EN_BIT];
  end

  always_comb begin
    rd_value         = '0;
    rd_value[EN_BIT] = enable;
  end
endmodule

// File: rtl/gis_req_gate.sv
module gis_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic eoi,
  input  logic any_set,
  output logic irq
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pending_q <= 1'b0;
    else if (eoi)                            pending_q <= 1'b0;
    else if (!pending_q && enable && any_set) pending_q <= 1'b1;
  end

  assign irq = pending_q && enable;
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gis_pkg::*;
#(
  parameter int NUM_GROUPS     = GIS_NUM_GROUPS,
  parameter int PINS_PER_GROUP = GIS_PINS_PER_GROUP,
  parameter int WORD_W         = GIS_WORD_W,
  parameter int ADDR_W         = GIS_ADDR_W,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = GIS_MASTER_ADDR,
  localparam int NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP,
  localparam int SUM_W         = 2 * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] int_sts,
  input  logic [NUM_PINS-1:0] wake_sts,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   sum_lo,
  output logic [WORD_W-1:0]   sum_hi,
  output logic                irq_out,
  output logic [WORD_W-1:0]   master_rd
);
  logic [SUM_W-1:0] summary;
  logic             enable;
  logic             eoi_pulse;

  gis_group_or #(
    .NUM_GROUPS(NUM_GROUPS), .PINS_PER_GROUP(PINS_PER_GROUP), .SUM_W(SUM_W)
  ) grp_i (
    .clk(clk), .rst_n(rst_n), .int_sts(int_sts), .wake_sts(wake_sts),
    .summary(summary)
  );

  gis_master_reg #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MASTER_ADDR(MASTER_ADDR),
    .EN_BIT(GIS_EN_BIT), .EOI_BIT(GIS_EOI_BIT)
  ) mst_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .enable(enable), .eoi_pulse(eoi_pulse),
    .rd_value(master_rd)
  );

  gis_req_gate req_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .eoi(eoi_pulse),
    .any_set(|summary), .irq(irq_out)
  );

  assign sum_lo = summary[WORD_W-1:0];
  assign sum_hi = summary[SUM_W-1:WORD_W];
endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
  parameter int NUM_PINS = 184,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] int_sts,
  input logic [NUM_PINS-1:0] wake_sts,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [WORD_W-1:0]   wr_data,
  input logic [WORD_W-1:0]   sum_lo,
  input logic [WORD_W-1:0]   sum_hi,
  input logic                irq_out,
  input logic [WORD_W-1:0]   master_rd
);
  logic mst_wr;
  assign mst_wr = wr_en && (wr_addr == MASTER_ADDR);

  AST_GROUP0_OR: assert property (@(posedge clk) disable iff (!rst_n)
    sum_lo[0] == $past(|(int_sts[3:0] | wake_sts[3:0]))); // R1
  AST_LAST_GROUP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    sum_hi[13] == $past(|(int_sts[183:180] | wake_sts[183:180]))); // R2
  AST_RAISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_out) && $past(master_rd[0])) |-> $past(|{sum_hi, sum_lo})); // R4
  AST_HOLD_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !mst_wr) |=> irq_out); // R5
  AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_wr && wr_data[1]) |=> !irq_out); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_rd[0] |-> !irq_out); // R8
endmodule

bind gpio_irq_summary gis_checker #(
  .NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .MASTER_ADDR(MASTER_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .int_sts(int_sts), .wake_sts(wake_sts),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sum_lo(sum_lo),
  .sum_hi(sum_hi), .irq_out(irq_out), .master_rd(master_rd)
);

// File: tb/gpio_irq_summary_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_summary_tb_top;
  localparam int NP = 184;
  localparam int NV = 8;
  localparam logic [11:0] MADDR = 12'h2FC;
  // vectors: interrupt pin, wake pin (255 = none), expected low and high words
  localparam int          V_INT [NV] = '{0, 255, 5, 127, 255, 183, 4, 255};
  localparam int          V_WAK [NV] = '{255, 3, 6, 255, 128, 255, 183, 255};
  localparam logic [31:0] V_LO  [NV] = '{32'h1, 32'h1, 32'h2, 32'h8000_0000,
                                         32'h0, 32'h0, 32'h2, 32'h0};
  localparam logic [31:0] V_HI  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                         32'h1, 32'h2000, 32'h2000, 32'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] int_sts = '0;
  logic [NP-1:0] wake_sts = '0;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sum_lo, sum_hi, master_rd;
  logic irq_out;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gpio_irq_summary dut_i (
    .clk(clk), .rst_n(rst_n), .int_sts(int_sts), .wake_sts(wake_sts),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sum_lo(sum_lo),
    .sum_hi(sum_hi), .irq_out(irq_out), .master_rd(master_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 sum_lo", sum_lo, 0);
    check("R10 sum_hi", sum_hi, 0);
    check("R10 irq", {31'b0, irq_out}, 0);
    check("R10 master", master_rd, 0);

    // table walk, enable off: R1 R2 R3, and R8 (no request while disabled)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      int_sts = '0; wake_sts = '0;
      if (V_INT[i] != 255) int_sts[V_INT[i]] = 1'b1;
      if (V_WAK[i] != 255) wake_sts[V_WAK[i]] = 1'b1;
      @(negedge clk);
      check("R1 R2 sum_lo", sum_lo, V_LO[i]);
      check("R2 R3 sum_hi", sum_hi, V_HI[i]);
      check("R8 irq while disabled", {31'b0, irq_out}, 0);
    end

    // R4: enable with a group set
    @(negedge clk); int_sts = '0; int_sts[50] = 1'b1;
    @(negedge clk);
    write(MADDR, 32'h1);
    check("R4 irq one cycle after enable", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R4 irq raised", {31'b0, irq_out}, 1);
    check("R7 enable readback", master_rd, 32'h1);

    // R5: held after summary clears
    int_sts = '0;
    repeat (3) @(negedge clk);
    check("R5 summary cleared", sum_lo | sum_hi, 0);
    check("R5 irq held", {31'b0, irq_out}, 1);

    // R6: EOI with empty summary, no re-raise; R7: EOI reads 0
    write(MADDR, 32'h3);
    check("R6 irq dropped", {31'b0, irq_out}, 0);
    repeat (2) @(negedge clk);
    check("R6 no re-raise when empty", {31'b0, irq_out}, 0);
    check("R7 EOI reads zero", master_rd, 32'h1);

    // R4 R6: new source, then EOI while still set
    wake_sts[10] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 irq from wake source", {31'b0, irq_out}, 1);
    write(MADDR, 32'h3);
    check("R6 irq dropped at EOI", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R6 re-raised while set", {31'b0, irq_out}, 1);

    // R9: write elsewhere ignored
    write(12'h000, 32'h0);
    check("R9 irq unchanged", {31'b0, irq_out}, 1);
    check("R9 master unchanged", master_rd, 32'h1);
    write(12'h2F8, 32'h2);
    check("R9 near address EOI ignored", {31'b0, irq_out}, 1);

    // R8: disable masks the request
    write(MADDR, 32'h0);
    check("R8 irq masked", {31'b0, irq_out}, 0);
    check("R8 master cleared", master_rd, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule